// File: doc/BRIEF.md
# Three-Way Line Strip Splitter

This block takes a raster pixel stream, one pixel per clock with a valid flag and a marker on the first pixel of each line, and cuts every line into three side-by-side vertical strips. Each strip goes to its own output channel. Each of the three downstream consumers therefore sees a narrower image with the same, unbounded number of lines. The split runs again on every line. Within each line the pixels are sent first to channel 0, then to channel 1, then to channel 2.

A position counter follows each pixel's place within its line. The line start marker forces that position to zero, and the counter wraps back to zero after the last pixel of a line. A steering stage compares the position against the strip boundaries. It picks one channel and flags the first and last pixel of that strip. A register stage per channel then presents the pixel with its valid strobe and strip markers. A sticky error flag records any line that is shorter or longer than the configured width. Line width and the widths of the first two strips are parameters. By default a line is 5000 pixels, split into strips of 1667, 1667 and 1666 pixels.

Top module: `line_strip_splitter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released with no input, every `ch_valid`, `ch_sol` and `ch_eol` bit is 0 and `len_err` is 0.
- R2: A pixel accepted with `in_valid` high appears, unchanged, in slice `ch_pix[c*12 +: 12]` of exactly one channel c on the clock after it is accepted, with `ch_valid[c]` high for that one cycle.
- R3: With the default parameters, line positions 0 to 1666 go to channel 0, positions 1667 to 3333 go to channel 1, and positions 3334 to 4999 go to channel 2.
- R4: A cycle with `in_valid` low produces no output strobe and does not advance the position, even if `in_sol` is high in that cycle.
- R5: `ch_sol[c]` is high together with `ch_valid[c]` exactly when the pixel is the first of strip c (positions 0, 1667 and 3334).
- R6: `ch_eol[c]` is high together with `ch_valid[c]` exactly when the pixel is the last of strip c (positions 1666, 3333 and 4999).
- R7: A valid pixel with `in_sol` high takes position 0. After position 4999 the position wraps to 0, so the next line starts again on channel 0.
- R8: A valid pixel with `in_sol` high that arrives while the position is not 0 (a short line) sets `len_err` on the next clock. The pixel is still steered as position 0.
- R9: A valid pixel without `in_sol` that arrives when a new line is expected (after reset, or after position 4999) sets `len_err` on the next clock. The pixel is still steered as position 0.
- R10: Once set, `len_err` stays high until reset, whatever lines follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Marks the first pixel of a line, qualified by in_valid |
| in_pix | input | 12 | Input pixel value |
| ch_valid | output | 3 | Per-channel pixel valid strobe |
| ch_sol | output | 3 | Per-channel first-pixel-of-strip marker |
| ch_eol | output | 3 | Per-channel last-pixel-of-strip marker |
| ch_pix | output | 36 | Per-channel pixel data, channel c in bits c*12 +: 12 |
| len_err | output | 1 | Sticky line-length error |

## Verification
A position counter that is off by even one count shows up at the ports as soon as a strip boundary is reached. The strobe moves to the wrong channel, and the start or end marker lands one pixel early or late. A position counter that fails to wrap shows up on the first pixel of the following line as a spurious `len_err`. A position counter that fails to resynchronise shows up one clock after the start marker arrives, as the wrong steering. A reference model compares every output on every clock over full lines, gapped lines, short lines and overlong lines. Because of this, no fault can hide for more than one strip width.

// File: rtl/lss_pkg.sv
package lss_pkg;

  localparam int unsigned NUM_CH = 3;

  // first position of strip ch, given the widths of strips 0 and 1
  function automatic int unsigned strip_lo(int unsigned ch, int unsigned w0, int unsigned w1);
    int unsigned lo;
    lo = 0;
    if (ch >= 1) lo = lo + w0;
    if (ch >= 2) lo = lo + w1;
    return lo;
  endfunction

  // last position of strip ch; the final strip ends at the line end
  function automatic int unsigned strip_hi(int unsigned ch, int unsigned w0, int unsigned w1,
                                           int unsigned line_len);
    int unsigned hi;
    if (ch == 0)      hi = w0 - 1;
    else if (ch == 1) hi = w0 + w1 - 1;
    else              hi = line_len - 1;
    return hi;
  endfunction

endpackage

// File: rtl/lss_pos_counter.sv
module lss_pos_counter #(
  parameter int unsigned LINE_LEN = 5000,
  parameter int unsigned POS_W    = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  output logic [POS_W-1:0] pos,
  output logic             short_evt,
  output logic             long_evt,
  output logic             len_err
);

  localparam int unsigned LAST_I = LINE_LEN - 1;
  localparam logic [POS_W-1:0] LAST = LAST_I[POS_W-1:0];

  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] cnt_d;
  logic             at_last;

  always_comb begin
    pos     = in_sol ? '0 : cnt_q;
    at_last = (pos == LAST);
    cnt_d   = at_last ? '0 : pos + 1'b1;
  end

  assign short_evt = in_valid && in_sol && (cnt_q != '0);
  assign long_evt  = in_valid && !in_sol && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_err <= 1'b0;
    end else begin
      if (in_valid) cnt_q <= cnt_d;
      if (short_evt || long_evt) len_err <= 1'b1;
    end
  end

  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

  // R8
  short_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> len_err);

  // R9
  long_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_evt |=> len_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

endmodule

// File: rtl/lss_steer.sv
module lss_steer #(
  parameter int unsigned LINE_LEN = 5000,
  parameter int unsigned STRIP0_W = 1667,
  parameter int unsigned STRIP1_W = 1667,
  parameter int unsigned POS_W    = $clog2(LINE_LEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [POS_W-1:0]           pos,
  output logic [lss_pkg::NUM_CH-1:0] sel,
  output logic [lss_pkg::NUM_CH-1:0] first,
  output logic [lss_pkg::NUM_CH-1:0] last
);

  localparam int unsigned NCH = lss_pkg::NUM_CH;

  for (genvar c = 0; c < NCH; c++) begin : g_bound
    localparam int unsigned LO_I = lss_pkg::strip_lo(c, STRIP0_W, STRIP1_W);
    localparam int unsigned HI_I = lss_pkg::strip_hi(c, STRIP0_W, STRIP1_W, LINE_LEN);
    localparam logic [POS_W-1:0] LO = LO_I[POS_W-1:0];
    localparam logic [POS_W-1:0] HI = HI_I[POS_W-1:0];

    always_comb begin
      sel[c]   = in_valid && (pos >= LO) && (pos <= HI);
      first[c] = in_valid && (pos == LO);
      last[c]  = in_valid && (pos == HI);
    end
  end

  // R2
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(sel) == 1);

  // R5
  first_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first & ~sel) == '0);

endmodule

// File: rtl/lss_chan_reg.sv
module lss_chan_reg #(
  parameter int unsigned PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             first,
  input  logic             last,
  input  logic [PIX_W-1:0] pix,
  output logic             o_valid,
  output logic             o_sol,
  output logic             o_eol,
  output logic [PIX_W-1:0] o_pix
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_sol   <= 1'b0;
      o_eol   <= 1'b0;
      o_pix   <= '0;
    end else begin
      o_valid <= sel;
      o_sol   <= sel && first;
      o_eol   <= sel && last;
      if (sel) o_pix <= pix;
    end
  end

  // R5
  sol_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_sol |-> o_valid);

  // R6
  eol_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_eol |-> o_valid);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(o_pix));

endmodule

// File: rtl/line_strip_splitter.sv
module line_strip_splitter #(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned LINE_LEN = 5000,
  parameter int unsigned STRIP0_W = (LINE_LEN + 2) / 3,
  parameter int unsigned STRIP1_W = (LINE_LEN + 1) / 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sol,
  input  logic [PIX_W-1:0]     in_pix,
  output logic [2:0]           ch_valid,
  output logic [2:0]           ch_sol,
  output logic [2:0]           ch_eol,
  output logic [3*PIX_W-1:0]   ch_pix,
  output logic                 len_err
);

  localparam int unsigned NCH   = lss_pkg::NUM_CH;
  localparam int unsigned POS_W = $clog2(LINE_LEN);

  logic [POS_W-1:0] pos;
  logic             short_evt;
  logic             long_evt;
  logic [NCH-1:0]   sel;
  logic [NCH-1:0]   first;
  logic [NCH-1:0]   last;

  lss_pos_counter #(
    .LINE_LEN (LINE_LEN),
    .POS_W    (POS_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .pos       (pos),
    .short_evt (short_evt),
    .long_evt  (long_evt),
    .len_err   (len_err)
  );

  lss_steer #(
    .LINE_LEN (LINE_LEN),
    .STRIP0_W (STRIP0_W),
    .STRIP1_W (STRIP1_W),
    .POS_W    (POS_W)
  ) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .pos      (pos),
    .sel      (sel),
    .first    (first),
    .last     (last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lss_chan_reg #(
      .PIX_W (PIX_W)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel[c]),
      .first   (first[c]),
      .last    (last[c]),
      .pix     (in_pix),
      .o_valid (ch_valid[c]),
      .o_sol   (ch_sol[c]),
      .o_eol   (ch_eol[c]),
      .o_pix   (ch_pix[c*PIX_W +: PIX_W])
    );
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(ch_valid) == 1);

  // R4
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ch_valid == '0);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_valid));

  // R7
  sol_restarts_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sol) |=> (ch_valid[0] && ch_sol[0]));

endmodule

// File: tb/line_strip_splitter_bench.sv
module line_strip_splitter_bench;

  localparam int LEN = 5000;
  localparam int B1  = 1667;
  localparam int B2  = 3334;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sol = 1'b0;
  logic [11:0] in_pix = '0;
  logic [2:0]  ch_valid, ch_sol, ch_eol;
  logic [35:0] ch_pix;
  logic        len_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string scen = "R1";

  int          m_cnt = 0;
  bit          m_err = 0;
  logic [11:0] m_pix [3] = '{default: 12'h0};

  always #10 clk = ~clk;

  line_strip_splitter u_line_strip_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
    .ch_valid(ch_valid), .ch_sol(ch_sol), .ch_eol(ch_eol), .ch_pix(ch_pix), .len_err(len_err)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", scen, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic step(bit v, bit s, logic [11:0] p);
    logic [2:0] ev, es, ee;
    int pos, ch;
    in_valid = v; in_sol = s; in_pix = p;
    ev = 0; es = 0; ee = 0;
    if (v) begin
      pos = s ? 0 : m_cnt;
      if (s && m_cnt != 0) m_err = 1;
      if (!s && m_cnt == 0) m_err = 1;
      ch = (pos < B1) ? 0 : (pos < B2) ? 1 : 2;
      ev[ch] = 1'b1;
      m_pix[ch] = p;
      if (pos == 0 || pos == B1 || pos == B2) es[ch] = 1'b1;
      if (pos == B1 - 1 || pos == B2 - 1 || pos == LEN - 1) ee[ch] = 1'b1;
      m_cnt = (pos == LEN - 1) ? 0 : pos + 1;
    end
    @(negedge clk);
    chk("ch_valid R3", 32'(ch_valid), 32'(ev));
    chk("ch_sol R5", 32'(ch_sol), 32'(es));
    chk("ch_eol R6", 32'(ch_eol), 32'(ee));
    chk("len_err", 32'(len_err), 32'(m_err));
    for (int c = 0; c < 3; c++) chk("ch_pix R2", 32'(ch_pix[c*12 +: 12]), 32'(m_pix[c]));
  endtask

  function automatic logic [11:0] pixval(int ln, int i);
    return 12'((i * 7 + ln * 131 + (i >> 3)) % 4096);
  endfunction

  task automatic send_line(int ln, int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) step(1'b0, 1'b1, 12'hABC);  // R4: marker while idle
      step(1'b1, i == 0, pixval(ln, i));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; in_sol = 0; in_pix = '0;
    m_cnt = 0; m_err = 0;
    for (int c = 0; c < 3; c++) m_pix[c] = '0;
    @(negedge clk);
    scen = "R1";
    chk("reset ch_valid R1", 32'(ch_valid), 0);
    chk("reset ch_sol R1", 32'(ch_sol), 0);
    chk("reset ch_eol R1", 32'(ch_eol), 0);
    chk("reset len_err R1", 32'(len_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    scen = "R3"; send_line(0, LEN, 0);
    scen = "R4"; send_line(1, LEN, 1);
    scen = "R7"; send_line(2, LEN, 0);
    send_line(3, 10, 0);
    scen = "R8"; send_line(4, 100, 0);
    send_line(5, LEN, 0);
    chk("short line len_err R8", 32'(len_err), 1);
    do_reset();
    scen = "R9"; send_line(6, LEN, 0);
    step(1'b1, 1'b0, 12'h5A5);
    chk("overlong len_err R9", 32'(len_err), 1);
    scen = "R10";
    send_line(7, 3, 0);
    m_cnt = m_cnt;
    send_line(8, 50, 1);
    chk("sticky len_err R10", 32'(len_err), 1);
    do_reset();
    scen = "R10"; chk("reset clears len_err R10", 32'(len_err), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule